// File: doc/BRIEF.md
# Byte-host to word-bus bridge

This block connects a processor with an 8-bit data path to a 16-bit expansion bus. The host issues one byte access at a time through a request strobe. The bridge runs a one-cycle command on the card side and acknowledges the host. On reads, a word-wide card keeps its whole 16-bit word in a holding latch, so the next odd-byte read is answered without a bus cycle. On writes, hardware steers the host byte onto the correct data lane from the card's 16-bit select and address bit 0. The host therefore never has to load a separate high-byte register first.

The bridge makes the byte-high-enable strobe itself when the card does not drive that line. The output is modelled as open drain: the bridge can only pull the line low, and a pull-up holds it high otherwise. A card that drives the strobe itself expects whole-word writes. In that mode the bridge holds an even-address byte in a staging register until the matching odd byte arrives, then writes both halves in a single command.

Top module: `isa_bridge`

## Requirements
- R1: After reset, host_ack_o, bus_rd_o, bus_wr_o, bus_sbhe_pull_o and bus_lane_oe_o are all 0.
- R2: A read that the latch does not serve runs exactly one bus_rd_o cycle. host_ack_o is high two cycles after the request is accepted. The returned byte is bus_dat_i[15:8] when bus_cs16_i=1 and address bit 0 is 1, otherwise bus_dat_i[7:0].
- R3: A read at an even address while bus_cs16_i=1 keeps the whole word. A following read of the odd byte of the same word returns bus_dat_i[15:8] of that word, with host_ack_o one cycle after the request and no bus cycle.
- R4: After the held high byte is delivered, the latch is empty, so another odd read of that word runs a bus cycle.
- R5: Any accepted write, or a read to a different word address, empties the latch, so a later odd read runs a bus cycle.
- R6: In a plain write, the host byte goes on bus_dat_o[15:8] with bus_lane_oe_o=2'b10 when bus_cs16_i=1 and address bit 0 is 1. Otherwise it goes on bus_dat_o[7:0] with bus_lane_oe_o=2'b01. The unused lane is 0.
- R7: bus_lane_oe_o is non-zero only while bus_wr_o is high.
- R8: When bus_sbhe_ext_i=0 at request, bus_sbhe_pull_o is 1 during the command of every read and every odd-address write, and 0 for even-address writes.
- R9: When bus_sbhe_ext_i=1 at request, bus_sbhe_pull_o stays 0.
- R10: With bus_sbhe_ext_i=1, an even-address write is staged. host_ack_o comes one cycle after the request and no bus cycle runs.
- R11: With bus_sbhe_ext_i=1, an odd write to the word of a staged byte runs one bus_wr_o cycle. It drives bus_addr_o bit 0 = 0, bus_dat_o = {odd byte, staged byte} and bus_lane_oe_o=2'b11.
- R12: A staged byte is discarded by any accepted access other than its odd partner. An odd write to another word then runs as a plain byte write at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe, taken when the bridge is idle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | AW | Host byte address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Read byte, valid with host_ack_o |
| host_ack_o | output | 1 | One-cycle completion pulse |
| bus_addr_o | output | AW | Card address, bit 0 is A0 |
| bus_rd_o | output | 1 | Read command phase |
| bus_wr_o | output | 1 | Write command phase |
| bus_dat_o | output | 16 | Write data toward the card |
| bus_lane_oe_o | output | 2 | Driver enable per lane, bit 1 = high lane |
| bus_dat_i | input | 16 | Data from the card |
| bus_cs16_i | input | 1 | Card claims a 16-bit access |
| bus_sbhe_ext_i | input | 1 | Card drives the byte-high-enable line itself |
| bus_sbhe_pull_o | output | 1 | Pull the byte-high-enable line low |

## Verification
The hardest state to reach is a latch hit. It needs a word-wide read at an even address, followed at once by an odd read of the same word, with no write or foreign-word read in between. The word-pair write is just as narrow: an even write and then an odd write to the same word, both in card-driven strobe mode. Random stimulus is confined to a handful of word addresses and mixes reads, writes, the 16-bit select and the strobe mode, so these pairings recur often. Directed sequences first force each hit, each miss after consumption and each discard.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_CMD = 1'b1} phase_e;

  // byte travels on D15:8 only for a word card at an odd address
  function automatic logic use_high_lane(input logic cs16, input logic a0);
    return cs16 & a0;
  endfunction
endpackage

// File: rtl/isa_rd_latch.sv
module isa_rd_latch #(
  parameter int TW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          keep_i,
  input  logic [15:0]   word_i,
  input  logic [TW-1:0] tag_i,
  input  logic          kill_i,
  output logic          valid_o,
  output logic [TW-1:0] tag_o,
  output logic [15:0]   word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      word_o  <= '0;
    end else if (load_i) begin
      valid_o <= keep_i;
      tag_o   <= tag_i;
      word_o  <= word_i;
    end else if (kill_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/isa_wr_stage.sv
module isa_wr_stage #(
  parameter int TW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          put_i,
  input  logic [7:0]    byte_i,
  input  logic [TW-1:0] tag_i,
  input  logic          drop_i,
  output logic          valid_o,
  output logic [TW-1:0] tag_o,
  output logic [7:0]    byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      byte_o  <= '0;
    end else if (put_i) begin
      valid_o <= 1'b1;
      tag_o   <= tag_i;
      byte_o  <= byte_i;
    end else if (drop_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/isa_bridge_seq.sv
module isa_bridge_seq
  import isa_bridge_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fast_ack_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          pair_i,
  input  logic          ext_i,
  output logic          cmd_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [7:0]    cmd_data_o,
  output logic          cmd_pair_o,
  output logic          cmd_ext_o,
  output logic          ack_o
);
  phase_e phase_q;

  assign cmd_o = (phase_q == PH_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      cmd_we_o   <= 1'b0;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
      cmd_pair_o <= 1'b0;
      cmd_ext_o  <= 1'b0;
      ack_o      <= 1'b0;
    end else begin
      ack_o <= fast_ack_i | cmd_o;
      if (start_i) begin
        phase_q    <= PH_CMD;
        cmd_we_o   <= we_i;
        cmd_addr_o <= addr_i;
        cmd_data_o <= data_i;
        cmd_pair_o <= pair_i;
        cmd_ext_o  <= ext_i;
      end else begin
        phase_q <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/isa_bridge.sv
module isa_bridge
  import isa_bridge_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  output logic          host_ack_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [15:0]   bus_dat_o,
  output logic [1:0]    bus_lane_oe_o,
  input  logic [15:0]   bus_dat_i,
  input  logic          bus_cs16_i,
  input  logic          bus_sbhe_ext_i,
  output logic          bus_sbhe_pull_o
);
  localparam int TW = AW - 1;

  logic          cmd, cmd_we, cmd_pair, cmd_ext;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          lat_valid, stg_valid;
  logic [TW-1:0] lat_tag, stg_tag;
  logic [15:0]   lat_word;
  logic [7:0]    stg_byte;

  logic          acc, a0, rd_hit, stg_put, pair, start, lat_kill;
  logic [TW-1:0] req_tag;
  logic          hi_lane;

  assign acc     = host_req_i & ~cmd;
  assign a0      = host_addr_i[0];
  assign req_tag = host_addr_i[AW-1:1];
  assign rd_hit  = acc & ~host_we_i & lat_valid & a0 & (lat_tag == req_tag);
  assign stg_put = acc & host_we_i & bus_sbhe_ext_i & ~a0;
  assign pair    = acc & host_we_i & bus_sbhe_ext_i & a0 & stg_valid & (stg_tag == req_tag);
  assign start   = acc & ~rd_hit & ~stg_put;
  assign lat_kill = rd_hit | (acc & host_we_i) | (acc & (req_tag != lat_tag));

  isa_bridge_seq #(.AW(AW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start), .fast_ack_i(rd_hit | stg_put),
    .we_i(host_we_i), .addr_i(host_addr_i), .data_i(host_wdata_i),
    .pair_i(pair), .ext_i(bus_sbhe_ext_i),
    .cmd_o(cmd), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .cmd_data_o(cmd_data), .cmd_pair_o(cmd_pair), .cmd_ext_o(cmd_ext),
    .ack_o(host_ack_o)
  );

  isa_rd_latch #(.TW(TW)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(cmd & ~cmd_we), .keep_i(bus_cs16_i & ~cmd_addr[0]),
    .word_i(bus_dat_i), .tag_i(cmd_addr[AW-1:1]), .kill_i(lat_kill),
    .valid_o(lat_valid), .tag_o(lat_tag), .word_o(lat_word)
  );

  isa_wr_stage #(.TW(TW)) u_stg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .put_i(stg_put), .byte_i(host_wdata_i), .tag_i(req_tag),
    .drop_i(acc & ~stg_put),
    .valid_o(stg_valid), .tag_o(stg_tag), .byte_o(stg_byte)
  );

  assign hi_lane  = use_high_lane(bus_cs16_i, cmd_addr[0]);
  assign bus_rd_o = cmd & ~cmd_we;
  assign bus_wr_o = cmd & cmd_we;
  assign bus_addr_o = cmd_pair ? {cmd_addr[AW-1:1], 1'b0} : cmd_addr;
  assign bus_sbhe_pull_o = cmd & ~cmd_ext & (~cmd_we | cmd_addr[0]);

  always_comb begin
    bus_dat_o     = '0;
    bus_lane_oe_o = 2'b00;
    if (bus_wr_o) begin
      if (cmd_pair) begin
        bus_dat_o     = {cmd_data, stg_byte};
        bus_lane_oe_o = 2'b11;
      end else if (hi_lane) begin
        bus_dat_o     = {cmd_data, 8'h00};
        bus_lane_oe_o = 2'b10;
      end else begin
        bus_dat_o     = {8'h00, cmd_data};
        bus_lane_oe_o = 2'b01;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_rdata_o <= '0;
    else if (rd_hit) host_rdata_o <= lat_word[15:8];
    else if (bus_rd_o) host_rdata_o <= hi_lane ? bus_dat_i[15:8] : bus_dat_i[7:0];
  end
endmodule

// File: rtl/isa_bridge_chk.sv
module isa_bridge_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_ack_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic [1:0]    bus_lane_oe_o,
  input logic          bus_cs16_i,
  input logic          bus_sbhe_pull_o
);
  // R2
  cmd_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_rd_o, bus_wr_o}));
  // R2
  cmd_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |=> !(bus_rd_o || bus_wr_o));
  // R2
  read_then_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |=> host_ack_o);
  // R7
  drive_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lane_oe_o != 2'b00) |-> (bus_wr_o && !bus_rd_o));
  // R6
  high_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lane_oe_o == 2'b10) |-> (bus_addr_o[0] && bus_cs16_i));
  // R11
  word_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lane_oe_o == 2'b11) |-> !bus_addr_o[0]);
  // R8
  pull_in_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_sbhe_pull_o |-> (bus_rd_o || bus_wr_o));
endmodule

bind isa_bridge isa_bridge_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_ack_o(host_ack_o),
  .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
  .bus_lane_oe_o(bus_lane_oe_o), .bus_cs16_i(bus_cs16_i),
  .bus_sbhe_pull_o(bus_sbhe_pull_o)
);

// File: tb/isa_bridge_test.sv
`timescale 1ns/1ps
module isa_bridge_test;
  localparam int AW = 20;
  localparam int TW = AW - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_req_i = 1'b0, host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [7:0]    host_wdata_i = '0;
  logic [7:0]    host_rdata_o;
  logic          host_ack_o;
  logic [AW-1:0] bus_addr_o;
  logic          bus_rd_o, bus_wr_o, bus_sbhe_pull_o;
  logic [15:0]   bus_dat_o, bus_dat_i;
  logic [1:0]    bus_lane_oe_o;
  logic          bus_cs16_i = 1'b0, bus_sbhe_ext_i = 1'b0;

  int n_chk = 0, n_bad = 0, bus_cnt = 0, oe_viol = 0, last_ncmd = 0;
  bit done = 1'b0;
  logic [AW-1:0] mon_addr;
  logic [15:0]   mon_dat;
  logic [1:0]    mon_oe;
  logic          mon_pull;

  // bench model state
  logic          m_valid = 1'b0, m_stg = 1'b0;
  logic [TW-1:0] m_tag = '0, m_stg_tag = '0;
  logic [7:0]    m_stg_byte = '0;

  always #4 clk_i = ~clk_i;

  function automatic logic [15:0] card_word(input logic [TW-1:0] t);
    return {t[7:0] * 8'd7 + 8'h91, t[7:0] ^ 8'h5A};
  endfunction

  assign bus_dat_i = card_word(bus_addr_o[AW-1:1]);

  isa_bridge #(.AW(AW)) uut (.*);

  always @(posedge clk_i) begin
    if (bus_rd_o || bus_wr_o) begin
      bus_cnt  <= bus_cnt + 1;
      mon_addr <= bus_addr_o;
      mon_dat  <= bus_dat_o;
      mon_oe   <= bus_lane_oe_o;
      mon_pull <= bus_sbhe_pull_o;
    end
    if (rst_ni && bus_lane_oe_o != 2'b00 && !bus_wr_o) oe_viol <= oe_viol + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                     input logic cs, input logic ex);
    int lat, n0, e_lat, e_n;
    logic [7:0] e_rd;
    logic [AW-1:0] e_addr;
    logic [15:0] e_dat;
    logic [1:0] e_oe;
    logic e_pull;
    string tg;
    logic [TW-1:0] t;
    t = a[AW-1:1];
    e_rd = '0; e_addr = a; e_dat = '0; e_oe = 2'b00; e_pull = 1'b0;
    if (!we) begin
      m_stg = 1'b0;
      if (m_valid && a[0] && m_tag == t) begin
        tg = "R3"; e_lat = 1; e_n = 0; e_rd = card_word(t)[15:8]; m_valid = 1'b0;
      end else begin
        tg = "R2"; e_lat = 2; e_n = 1;
        e_rd = (cs && a[0]) ? card_word(t)[15:8] : card_word(t)[7:0];
        e_pull = !ex; m_valid = cs && !a[0]; m_tag = t;
      end
    end else begin
      m_valid = 1'b0;
      if (ex && !a[0]) begin
        tg = "R10"; e_lat = 1; e_n = 0;
        m_stg = 1'b1; m_stg_tag = t; m_stg_byte = d;
      end else if (ex && a[0] && m_stg && m_stg_tag == t) begin
        tg = "R11"; e_lat = 2; e_n = 1; e_addr = {t, 1'b0};
        e_dat = {d, m_stg_byte}; e_oe = 2'b11; m_stg = 1'b0;
      end else begin
        tg = "R6"; e_lat = 2; e_n = 1; m_stg = 1'b0;
        e_dat = (cs && a[0]) ? {d, 8'h00} : {8'h00, d};
        e_oe  = (cs && a[0]) ? 2'b10 : 2'b01;
        e_pull = !ex && a[0];
      end
    end
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = we; host_addr_i = a; host_wdata_i = d;
    bus_cs16_i = cs; bus_sbhe_ext_i = ex; n0 = bus_cnt;
    @(negedge clk_i);
    host_req_i = 1'b0; lat = 1;
    while (!host_ack_o && lat < 16) begin @(negedge clk_i); lat++; end
    last_ncmd = bus_cnt - n0;
    chk(tg, lat, e_lat);
    chk(tg, last_ncmd, e_n);
    if (!we) chk(tg, host_rdata_o, e_rd);
    if (e_n == 1) begin
      chk(ex ? "R9" : "R8", mon_pull, e_pull);
      if (we) begin
        chk(tg, mon_addr, e_addr);
        chk(tg, mon_dat, e_dat);
        chk(tg, mon_oe, e_oe);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0C16);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {host_ack_o, bus_rd_o, bus_wr_o, bus_sbhe_pull_o, bus_lane_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {host_ack_o, bus_rd_o, bus_wr_o, bus_sbhe_pull_o, bus_lane_oe_o}, 0);

    acc(0, 20'h10, 0, 1, 0);          // word capture
    acc(0, 20'h11, 0, 1, 0);          // R3 served from latch
    acc(0, 20'h11, 0, 1, 0);
    chk("R4", last_ncmd, 1);
    acc(0, 20'h10, 0, 1, 0);
    acc(1, 20'h20, 8'h3C, 1, 0);      // write kills latch
    acc(0, 20'h11, 0, 1, 0);
    chk("R5", last_ncmd, 1);
    acc(0, 20'h10, 0, 1, 0);
    acc(0, 20'h31, 0, 1, 0);          // foreign word read
    acc(0, 20'h11, 0, 1, 0);
    chk("R5", last_ncmd, 1);
    acc(1, 20'h21, 8'hC3, 1, 0);      // R6 high lane, R8 pull
    acc(1, 20'h21, 8'h7E, 0, 0);      // R6 8-bit card low lane
    acc(0, 20'h15, 0, 0, 1);          // R9 no pull
    acc(1, 20'h40, 8'hAA, 1, 1);      // R10 staged
    acc(1, 20'h41, 8'hBB, 1, 1);      // R11 word write
    acc(1, 20'h40, 8'h11, 1, 1);
    acc(1, 20'h43, 8'h22, 1, 1);      // R12 partner missing
    chk("R12", mon_addr, 20'h43);
    chk("R12", mon_oe, 2'b10);

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) a = AW'($urandom);
      acc($urandom_range(0, 9) < 4, a, 8'($urandom),
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
    end

    chk("R7", oe_viol, 0);
    finish_run();
  end
endmodule